// File: doc/BRIEF.md
# Dimension-Ordered Wormhole Mesh Router

This block is one node of a small two-dimensional on-chip network. It has five link pairs: one toward the local processing core and one each toward the north, east, south and west neighbours. Every link carries 32-bit flits under a request/acknowledge handshake. The first flit of a packet is a header that holds the destination column and row. The router settles on an output port by finishing the column direction before it moves along the row direction. That output then stays reserved for the packet until its last flit has passed.

Each input has a small flit queue. A header at the head of a queue goes through a fixed-length routing decision and then competes for its output with the other waiting headers under a rotating priority. The winner keeps the output for the rest of its packet, so packets never interleave on one link. A parameter selects between plain mesh routing and ring-aware routing for a wrapped (torus) arrangement. In the torus variant, each dimension takes the shorter way around.

Top module: `xy_mesh_router`

## Requirements
- R1: A header carries the destination column in bits [1:0], the destination row in bit [2], and a tail flag in bit [31], which marks the last flit of a packet. When the destination column differs from the router's own column, the packet leaves on East if the destination column is larger and on West if it is smaller, whatever the row.
- R2: When the column already matches and the row does not, the packet leaves on North if the destination row is larger and on South if it is smaller.
- R3: When both column and row match the router's own position, the packet leaves on the Local port.
- R4: In the torus variant, each dimension goes the shorter way around its ring. An equal distance resolves to East in the column dimension and to North in the row dimension.
- R5: On an idle router with a free output, the output request rises exactly four clock edges after the edge that accepts the header: three edges for the routing decision and one for the grant.
- R6: Once an output is granted to a packet, it carries every flit of that packet in order up to and including the tail before it carries any flit of another packet.
- R7: Headers that wait for the same output are served in rotating order, starting with the input just after the previous winner (port order Local 0, North 1, East 2, South 3, West 4).
- R8: Each input stores at most four flits. It acknowledges a request only in a cycle when it stores that flit, and none of the stored flits is lost while its output is stalled.
- R9: While an output request is high and unacknowledged, the request stays high and the flit stays unchanged.
- R10: After reset no output request is raised, and every input acknowledges a request because its queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 5 | Flit request per input link (Local, North, East, South, West) |
| in_flit | input | 5x32 | Flit data per input link |
| in_ack | output | 5 | Flit stored this cycle, per input link |
| out_req | output | 5 | Flit offered per output link |
| out_flit | output | 5x32 | Flit data per output link |
| out_ack | input | 5 | Downstream accepted the offered flit, per output link |

## Verification
A wrong route register shows up within about five cycles of a header's arrival, because the flit appears on the wrong output link. A broken reservation or a broken rotating pointer does not show with one packet in flight. It shows as flits of two packets mixed on one link, or as waiting packets leaving in the wrong order, so the directed scenarios queue several headers behind a stalled output and then release it. A counter fault in the queue shows once the queue is full: an acknowledge given when no room is left, or a flit missing from the released stream.

// File: rtl/xyr_pkg.sv
package xyr_pkg;
   localparam int NPORT = 5;

   typedef enum logic [2:0] {
      P_LOCAL = 3'd0,
      P_NORTH = 3'd1,
      P_EAST  = 3'd2,
      P_SOUTH = 3'd3,
      P_WEST  = 3'd4
   } port_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ROUTE,
      S_WAIT,
      S_FWD
   } in_state_e;
endpackage

// File: rtl/xyr_route.sv
module xyr_route
   import xyr_pkg::*;
#(
   parameter int NX    = 4,
   parameter int NY    = 2,
   parameter int MY_X  = 1,
   parameter int MY_Y  = 0,
   parameter bit TORUS = 1'b0,
   localparam int XW   = $clog2(NX),
   localparam int YW   = $clog2(NY)
) (
   input  logic [XW-1:0] dst_x,
   input  logic [YW-1:0] dst_y,
   output port_e         dir
);
   generate
      if (TORUS) begin : g_torus
         int dx, dy;
         always_comb begin
            dx = (int'(dst_x) - MY_X + NX) % NX;
            dy = (int'(dst_y) - MY_Y + NY) % NY;
            if (dx != 0)
               dir = (2 * dx <= NX) ? P_EAST : P_WEST;
            else if (dy != 0)
               dir = (2 * dy <= NY) ? P_NORTH : P_SOUTH;
            else
               dir = P_LOCAL;
         end
      end else begin : g_mesh
         always_comb begin
            if (dst_x != XW'(MY_X))
               dir = (dst_x > XW'(MY_X)) ? P_EAST : P_WEST;
            else if (dst_y != YW'(MY_Y))
               dir = (dst_y > YW'(MY_Y)) ? P_NORTH : P_SOUTH;
            else
               dir = P_LOCAL;
         end
      end
   endgenerate
endmodule

// File: rtl/xyr_fifo.sv
module xyr_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic         full,
   output logic         valid,
   output logic [W-1:0] head
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] count;

   assign full  = (count == CW'(DEPTH));
   assign valid = (count != '0);
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_en) begin
            mem[wp] <= wr_data;
            wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         end
         if (rd_en)
            rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         count <= count + CW'(wr_en) - CW'(rd_en);
      end
   end

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> count != '0);
endmodule

// File: rtl/xyr_in_ctrl.sv
module xyr_in_ctrl
   import xyr_pkg::*;
#(
   parameter int NX        = 4,
   parameter int NY        = 2,
   parameter int MY_X      = 1,
   parameter int MY_Y      = 0,
   parameter bit TORUS     = 1'b0,
   parameter int ROUTE_LAT = 3,
   localparam int XW       = $clog2(NX),
   localparam int YW       = $clog2(NY),
   localparam int CNTW     = $clog2(ROUTE_LAT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            head_valid,
   input  logic [XW+YW-1:0] head_xy,
   input  logic            granted,
   input  logic            tail_done,
   output logic            want,
   output port_e           route
);
   in_state_e     st;
   logic [CNTW-1:0] cnt;
   port_e         dir;

   xyr_route #(
      .NX(NX), .NY(NY), .MY_X(MY_X), .MY_Y(MY_Y), .TORUS(TORUS)
   ) u_route (
      .dst_x (head_xy[XW-1:0]),
      .dst_y (head_xy[XW+YW-1:XW]),
      .dir   (dir)
   );

   assign want = (st == S_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cnt   <= '0;
         route <= P_LOCAL;
      end else begin
         unique case (st)
            S_IDLE: if (head_valid) begin
               route <= dir;
               cnt   <= '0;
               st    <= S_ROUTE;
            end
            S_ROUTE: begin
               if (cnt == CNTW'(ROUTE_LAT - 2)) st <= S_WAIT;
               else                             cnt <= cnt + 1'b1;
            end
            S_WAIT:  if (granted)   st <= S_FWD;
            S_FWD:   if (tail_done) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   a_r7_grant_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      granted |-> st == S_WAIT);
endmodule

// File: rtl/xyr_out_arb.sv
module xyr_out_arb #(
   parameter int N   = 5,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          fire,
   input  logic          fire_tail,
   output logic          locked,
   output logic [IW-1:0] owner,
   output logic [N-1:0]  gnt
);
   logic [IW-1:0] ptr, win;
   logic          found;
   int            idx;

   always_comb begin
      found = 1'b0;
      win   = '0;
      idx   = 0;
      for (int k = 0; k < N; k++) begin
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            found = 1'b1;
            win   = IW'(idx);
         end
      end
      gnt = '0;
      if (found && !locked) gnt[win] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         owner  <= '0;
         ptr    <= '0;
      end else if (!locked) begin
         if (found) begin
            locked <= 1'b1;
            owner  <= win;
            ptr    <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
         end
      end else if (fire && fire_tail) begin
         locked <= 1'b0;
      end
   end

   a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r6_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(fire && fire_tail)) |=> (locked && $stable(owner)));
endmodule

// File: rtl/xy_mesh_router.sv
module xy_mesh_router
   import xyr_pkg::*;
#(
   parameter int FLIT_W    = 32,
   parameter int NX        = 4,
   parameter int NY        = 2,
   parameter int MY_X      = 1,
   parameter int MY_Y      = 0,
   parameter bit TORUS     = 1'b0,
   parameter int DEPTH     = 4,
   parameter int ROUTE_LAT = 3,
   localparam int XW       = $clog2(NX),
   localparam int YW       = $clog2(NY),
   localparam int IW       = $clog2(NPORT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORT-1:0]              in_req,
   input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
   output logic [NPORT-1:0]              in_ack,
   output logic [NPORT-1:0]              out_req,
   output logic [NPORT-1:0][FLIT_W-1:0]  out_flit,
   input  logic [NPORT-1:0]              out_ack
);
   generate
      if (NX < 2 || NY < 2) begin : g_bad_dim
         $error("mesh needs at least two columns and two rows");
      end
      if (MY_X >= NX || MY_Y >= NY) begin : g_bad_pos
         $error("router position lies outside the mesh");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("input queue depth must be at least two");
      end
      if (ROUTE_LAT < 2) begin : g_bad_lat
         $error("routing latency must be at least two cycles");
      end
      if (FLIT_W <= XW + YW + 1) begin : g_bad_width
         $error("flit too narrow for coordinates and tail flag");
      end
   endgenerate

   logic [FLIT_W-1:0] head   [NPORT];
   logic [NPORT-1:0]  valid, full, want, granted, pop, tail_done;
   port_e             route  [NPORT];
   logic [NPORT-1:0]  req_to [NPORT];
   logic [NPORT-1:0]  gnt    [NPORT];
   logic [IW-1:0]     owner  [NPORT];
   logic [NPORT-1:0]  locked, fire;

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      assign in_ack[i]    = in_req[i] && !full[i];
      assign tail_done[i] = pop[i] && head[i][FLIT_W-1];

      xyr_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (in_req[i] && in_ack[i]),
         .wr_data (in_flit[i]),
         .rd_en   (pop[i]),
         .full    (full[i]),
         .valid   (valid[i]),
         .head    (head[i])
      );

      xyr_in_ctrl #(
         .NX(NX), .NY(NY), .MY_X(MY_X), .MY_Y(MY_Y),
         .TORUS(TORUS), .ROUTE_LAT(ROUTE_LAT)
      ) u_ctrl (
         .clk        (clk),
         .rst_n      (rst_n),
         .head_valid (valid[i]),
         .head_xy    (head[i][XW+YW-1:0]),
         .granted    (granted[i]),
         .tail_done  (tail_done[i]),
         .want       (want[i]),
         .route      (route[i])
      );
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      for (genvar i = 0; i < NPORT; i++) begin : g_req
         assign req_to[o][i] = want[i] && (route[i] == port_e'(o));
      end

      assign out_req[o]  = locked[o] && valid[owner[o]];
      assign out_flit[o] = head[owner[o]];
      assign fire[o]     = out_req[o] && out_ack[o];

      xyr_out_arb #(.N(NPORT)) u_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_to[o]),
         .fire      (fire[o]),
         .fire_tail (out_flit[o][FLIT_W-1]),
         .locked    (locked[o]),
         .owner     (owner[o]),
         .gnt       (gnt[o])
      );

      a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (out_req[o] && !out_ack[o]) |=> (out_req[o] && $stable(out_flit[o])));
   end

   always_comb begin
      pop     = '0;
      granted = '0;
      for (int i = 0; i < NPORT; i++) begin
         for (int o = 0; o < NPORT; o++) begin
            if (fire[o] && owner[o] == IW'(i)) pop[i] = 1'b1;
            if (gnt[o][i])                     granted[i] = 1'b1;
         end
      end
   end
endmodule

// File: tb/xy_mesh_router_tb.sv
`timescale 1ns/1ps
module xy_mesh_router_tb;
   localparam int PL = 0, PN = 1, PE = 2, PS = 3, PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [4:0]        in_req = '0, in_ack, out_req, out_ack = '0;
   logic [4:0][31:0]  in_flit = '0, out_flit;
   logic [4:0]        t_in_req = '0, t_in_ack, t_out_req, t_out_ack = '1;
   logic [4:0][31:0]  t_in_flit = '0, t_out_flit;

   int nchecks = 0, nerrors = 0;
   int ngot [5];
   logic [31:0] got [5][16];
   int tcnt [5];

   xy_mesh_router #(.MY_X(1), .MY_Y(0), .TORUS(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_flit(in_flit),
      .in_ack(in_ack), .out_req(out_req), .out_flit(out_flit), .out_ack(out_ack));

   xy_mesh_router #(.MY_X(0), .MY_Y(0), .TORUS(1'b1)) u_tor (
      .clk(clk), .rst_n(rst_n), .in_req(t_in_req), .in_flit(t_in_flit),
      .in_ack(t_in_ack), .out_req(t_out_req), .out_flit(t_out_flit), .out_ack(t_out_ack));

   always @(posedge clk) begin
      for (int o = 0; o < 5; o++) begin
         if (out_req[o] && out_ack[o]) begin
            if (ngot[o] < 16) got[o][ngot[o]] = out_flit[o];
            ngot[o]++;
         end
         if (t_out_req[o] && t_out_ack[o]) tcnt[o]++;
      end
   end

   function automatic logic [31:0] mk(int x, int y, bit tail, int tag);
      return {tail, 28'(tag), 1'(y), 2'(x)};
   endfunction

   task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
      nchecks++;
      if (act !== exp) begin
         nerrors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_req = '0; out_ack = '0;
      repeat (3) @(negedge clk);
      for (int o = 0; o < 5; o++) begin ngot[o] = 0; tcnt[o] = 0; end
      rst_n = 1'b1;
   endtask

   task automatic send(int p, logic [31:0] f);
      @(negedge clk);
      in_req[p] = 1'b1; in_flit[p] = f;
      #1;
      while (!in_ack[p]) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      in_req[p] = 1'b0;
   endtask

   task automatic send_t(logic [31:0] f);
      @(negedge clk);
      t_in_req[PL] = 1'b1; t_in_flit[PL] = f;
      #1;
      while (!t_in_ack[PL]) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      t_in_req[PL] = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R10", "out_req after reset", 32'(out_req), 32'h0);
      @(negedge clk);
      in_req[PS] = 1'b1; in_flit[PS] = mk(1, 0, 1, 1);
      #1;
      check("R10", "ack with empty queue", 32'(in_ack[PS]), 32'h1);
      in_req[PS] = 1'b0;
   endtask

   task automatic route_case(string rq, int x, int y, int exp_port);
      do_reset();
      out_ack = '1;
      send(PL, mk(x, y, 1, 8'h5A));
      repeat (10) @(negedge clk);
      check(rq, $sformatf("flit count on port %0d for (%0d,%0d)", exp_port, x, y),
            32'(ngot[exp_port]), 32'h1);
      check(rq, "total flits", 32'(ngot[0] + ngot[1] + ngot[2] + ngot[3] + ngot[4]), 32'h1);
   endtask

   task automatic t_routes();
      route_case("R1", 0, 0, PW);
      route_case("R1", 3, 0, PE);
      route_case("R1", 2, 1, PE);
      route_case("R2", 1, 1, PN);
      route_case("R3", 1, 0, PL);
   endtask

   task automatic t_latency();
      int first;
      do_reset();
      out_ack = '1;
      first = -1;
      send(PW, mk(1, 0, 1, 7));
      for (int k = 1; k <= 8; k++) begin
         @(posedge clk); #1;
         if (out_req[PL] && first < 0) first = k;
      end
      check("R5", "edges from header accept to out_req", 32'(first), 32'd4);
   endtask

   task automatic t_wormhole();
      logic [31:0] ex [5];
      ex[0] = mk(2, 0, 0, 'hA0); ex[1] = mk(2, 0, 0, 'hA1); ex[2] = mk(2, 0, 1, 'hA2);
      ex[3] = mk(2, 0, 0, 'hB0); ex[4] = mk(2, 0, 1, 'hB1);
      do_reset();
      send(PW, ex[0]); send(PW, ex[1]); send(PW, ex[2]);
      send(PL, ex[3]); send(PL, ex[4]);
      repeat (8) @(negedge clk);
      check("R9", "out_req held while stalled", 32'(out_req[PE]), 32'h1);
      check("R9", "first offered flit", out_flit[PE], ex[0]);
      repeat (3) @(negedge clk);
      check("R9", "flit unchanged while stalled", out_flit[PE], ex[0]);
      out_ack[PE] = 1'b1;
      repeat (20) @(negedge clk);
      check("R6", "flits delivered east", 32'(ngot[PE]), 32'd5);
      for (int k = 0; k < 5; k++)
         check("R6", $sformatf("east flit %0d", k), got[PE][k], ex[k]);
   endtask

   task automatic t_round_robin();
      logic [31:0] ex [4];
      ex[0] = mk(2, 0, 1, 'h10); ex[1] = mk(2, 0, 1, 'h30);
      ex[2] = mk(2, 0, 1, 'h40); ex[3] = mk(2, 0, 1, 'h20);
      do_reset();
      send(PN, ex[0]);
      send(PL, ex[3]);
      send(PS, ex[1]);
      send(PW, ex[2]);
      repeat (10) @(negedge clk);
      out_ack[PE] = 1'b1;
      repeat (25) @(negedge clk);
      check("R7", "flits delivered east", 32'(ngot[PE]), 32'd4);
      for (int k = 0; k < 4; k++)
         check("R7", $sformatf("service order slot %0d", k), got[PE][k], ex[k]);
   endtask

   task automatic t_buffer();
      logic [31:0] f [6];
      int idx;
      bit a;
      for (int k = 0; k < 6; k++) f[k] = mk(2, 0, k == 5, 'hC0 + k);
      do_reset();
      idx = 0;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         in_req[PW] = 1'b1; in_flit[PW] = f[idx];
         #1; a = in_ack[PW];
         @(posedge clk); #1;
         if (a) idx++;
      end
      check("R8", "flits accepted with output stalled", 32'(idx), 32'd4);
      @(negedge clk); #1;
      check("R8", "ack withheld when queue full", 32'(in_ack[PW]), 32'h0);
      out_ack[PE] = 1'b1;
      for (int c = 0; c < 40 && idx < 6; c++) begin
         @(negedge clk);
         in_req[PW] = 1'b1; in_flit[PW] = f[idx];
         #1; a = in_ack[PW];
         @(posedge clk); #1;
         if (a) idx++;
      end
      in_req[PW] = 1'b0;
      repeat (15) @(negedge clk);
      check("R8", "flits delivered after release", 32'(ngot[PE]), 32'd6);
      for (int k = 0; k < 6; k++)
         check("R8", $sformatf("released flit %0d", k), got[PE][k], f[k]);
   endtask

   task automatic t_torus();
      do_reset();
      send_t(mk(3, 0, 1, 1));
      repeat (10) @(negedge clk);
      check("R4", "column distance 3 of 4 goes west", 32'(tcnt[PW]), 32'h1);
      send_t(mk(2, 0, 1, 2));
      repeat (10) @(negedge clk);
      check("R4", "column tie goes east", 32'(tcnt[PE]), 32'h1);
      send_t(mk(0, 1, 1, 3));
      repeat (10) @(negedge clk);
      check("R4", "row tie goes north", 32'(tcnt[PN]), 32'h1);
   endtask

   initial begin
      #(8 * 150000);
      nerrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_routes();
      t_latency();
      t_wormhole();
      t_round_robin();
      t_buffer();
      t_torus();
      finish_run();
   end
endmodule